// File: doc/BRIEF.md
# Three-Pin GPIO Slice with Special-Output Override

This block holds three general-purpose I/O pins. Each pin has four control bits: a data value, a direction, a pull-down enable and an input-level select. Software reads and writes these bits over a small synchronous register bus. Each pin can also be handed to one special output source. Pin 0 carries a buzzer signal, pin 1 carries a programmable-timer clock, and pin 2 carries a divided oscillator clock. While its special output is on, a pin drives as an output from that source. The pin's own four bits then stay readable and writable but no longer reach the pad.

Pin 2 is driven by a clock-output divider inside the block. The divider is steered by a 4-bit select code. Code 0 leaves the pin as plain GPIO. Codes 1 to 7 tap the low-speed oscillator divided by 2^(code-1). Codes 8 to 15 tap the high-speed oscillator divided by 2^(code-8). Both oscillators are synchronised into the block clock and counted there. The timer clock is routed to its pin through combinational gating only. Because that enable is not aligned to the timer clock, switching it on or off can leave a short runt pulse on the pin.

The buzzer generator, the timer and the oscillators are outside this block and arrive as input signals.

Top module: `altfn_gpio_port`

## Requirements
- R1: After reset, every pin is an input (pad_oe 0) with its pull-down active (pad_pd 1) and pad_out 0. Registers at addresses 0, 1, 3, 4 and 5 read 0, and address 2 reads 4'b0111.
- R2: With no special output on, pin i drives pad_oe[i] from direction bit i and pad_out[i] from data bit i. pad_pd[i] is the pull-down bit gated by "direction is input". pad_lvl[i] follows level bit i.
- R3: Register addresses are: 0 data, 1 direction (1 = output), 2 pull-down, 3 input level, 4 control, 5 frequency select. Bit i of addresses 0 to 3 belongs to pin i. Each address reads back the value last written, masked to its width: 3 bits, except address 5, which holds 4 bits.
- R4: A read of address 6 returns pad_in[2:0] in the low bits with bit 3 at 0. A write to address 6 changes nothing.
- R5: Control bit 0 set turns on the buzzer output. pin 0 then has pad_oe 1, pad_out equal to buzz_in, and pad_pd 0.
- R6: Control bit 1 appears on buzz_shot and has no effect on any pad.
- R7: Control bit 2 set turns on the timer-clock output. pin 1 then has pad_oe 1, and pad_out follows tout_in in the same cycle with no clock delay.
- R8: A frequency select of 0 leaves pin 2 as GPIO. Any non-zero code turns pin 2 into an output with pull-down off.
- R9: Codes 1 to 7 make pin 2 a square wave whose period is the low-speed oscillator period times 2^(code-1).
- R10: Codes 8 to 15 make pin 2 a square wave whose period is the high-speed oscillator period times 2^(code-8).
- R11: While a pin's special output is on, writes to its data, direction, pull-down and level bits are stored and read back, but they do not change its pad signals, and its pad_lvl is 0. When the special output is turned off, the pin takes up the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for reg_addr (combinational) |
| buzz_in | input | 1 | Buzzer generator output |
| tout_in | input | 1 | Timer toggle clock |
| osc_lo | input | 1 | Low-speed oscillator clock |
| osc_hi | input | 1 | High-speed oscillator clock |
| buzz_shot | output | 1 | One-shot burst request to the buzzer generator |
| pad_in | input | 3 | Pin levels seen at the pads |
| pad_oe | output | 3 | Pad output enables |
| pad_out | output | 3 | Pad output values |
| pad_pd | output | 3 | Pad pull-down enables |
| pad_lvl | output | 3 | Pad input-level selects |

## Verification
The bench writes direction, data and pull-down bits while each special output is active. A design that let those registers leak through would flip pad_oe or pad_out, or would stop returning the written values on read-back. The bench sweeps all fifteen divider codes and measures the pin 2 period. An off-by-one tap, or a swapped oscillator at the code 7 to 8 boundary, shows up as a period that is wrong by a factor of two or more. The bench toggles tout_in between clock edges. A registered timer path would lag by a cycle. It also toggles buzz_shot and checks that the pads stay unchanged.

// File: rtl/altfn_gpio_pkg.sv
package altfn_gpio_pkg;
  localparam int NPINS   = 3;
  localparam int DW      = 4;
  localparam int AW      = 3;
  localparam int SELW    = 4;
  localparam int LO_BITS = 6;   // low oscillator: divide up to 2^6
  localparam int HI_BITS = 7;   // high oscillator: divide up to 2^7
  localparam int TAPW    = 3;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_DIR  = 3'd1;
  localparam logic [AW-1:0] A_PULL = 3'd2;
  localparam logic [AW-1:0] A_LVL  = 3'd3;
  localparam logic [AW-1:0] A_CTRL = 3'd4;
  localparam logic [AW-1:0] A_FSEL = 3'd5;
  localparam logic [AW-1:0] A_PINS = 3'd6;

  // Select code 8..15 picks the high oscillator.
  function automatic logic fsel_uses_hi(input logic [SELW-1:0] code);
    return code[SELW-1];
  endfunction

  // Divider tap: 0 means undivided; tap k means divide by 2^k.
  function automatic logic [TAPW-1:0] fsel_tap(input logic [SELW-1:0] code);
    logic [SELW-1:0] t;
    t = code[SELW-1] ? code - 4'd8 : code - 4'd1;
    return t[TAPW-1:0];
  endfunction
endpackage

// File: rtl/altfn_pin_cell.sv
module altfn_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_dat,
  input  logic wr_dir,
  input  logic wr_pull,
  input  logic wr_lvl,
  input  logic wbit,
  input  logic alt_en,
  input  logic alt_val,
  output logic dat_q,
  output logic dir_q,
  output logic pull_q,
  output logic lvl_q,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_pd,
  output logic pad_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= 1'b0;
      dir_q  <= 1'b0;
      pull_q <= 1'b1;
      lvl_q  <= 1'b0;
    end else begin
      if (wr_dat)  dat_q  <= wbit;
      if (wr_dir)  dir_q  <= wbit;
      if (wr_pull) pull_q <= wbit;
      if (wr_lvl)  lvl_q  <= wbit;
    end
  end

  // Special output wins over every GPIO bit.
  assign pad_oe  = alt_en | dir_q;
  assign pad_out = alt_en ? alt_val : dat_q;
  assign pad_pd  = !alt_en && !dir_q && pull_q;
  assign pad_lvl = !alt_en && lvl_q;
endmodule

// File: rtl/altfn_clkout_div.sv
module altfn_clkout_div
  import altfn_gpio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_lo,
  input  logic            osc_hi,
  input  logic [SELW-1:0] sel,
  output logic            clk_out
);
  localparam int NSRC = 2;
  localparam int MAXW = (LO_BITS > HI_BITS) ? LO_BITS : HI_BITS;

  logic [NSRC-1:0]  src_raw;
  logic [NSRC-1:0]  src_lvl;
  logic [NSRC-1:0]  src_rise;
  logic [MAXW-1:0]  cnt [NSRC];

  assign src_raw = {osc_hi, osc_lo};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [2:0] sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        cnt[s] <= '0;
      end else begin
        sync_q <= {sync_q[1:0], src_raw[s]};
        if (sync_q[1] && !sync_q[2]) cnt[s] <= cnt[s] + 1'b1;
      end
    end
    assign src_lvl[s]  = sync_q[1];
    assign src_rise[s] = sync_q[1] && !sync_q[2];
  end

  logic [LO_BITS:0] lo_taps;
  logic [HI_BITS:0] hi_taps;
  logic [TAPW-1:0]  tap;

  assign lo_taps = {cnt[0][LO_BITS-1:0], src_lvl[0]};
  assign hi_taps = {cnt[1][HI_BITS-1:0], src_lvl[1]};
  assign tap     = fsel_tap(sel);

  always_comb begin
    if (sel == '0)              clk_out = 1'b0;
    else if (fsel_uses_hi(sel)) clk_out = hi_taps[tap];
    else                        clk_out = (tap <= TAPW'(LO_BITS)) ? lo_taps[tap] : 1'b0;
  end
endmodule

// File: rtl/altfn_gpio_port.sv
module altfn_gpio_port
  import altfn_gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             buzz_in,
  input  logic             tout_in,
  input  logic             osc_lo,
  input  logic             osc_hi,
  output logic             buzz_shot,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pd,
  output logic [NPINS-1:0] pad_lvl
);
  logic [2:0]       ctrl_q;
  logic [SELW-1:0]  fsel_q;
  logic             buzz_en, tmr_en, fout_en, fout_clk;
  logic [NPINS-1:0] alt_en, alt_val;
  logic [NPINS-1:0] dat_v, dir_v, pull_v, lvl_v;
  logic             wr_dat, wr_dir, wr_pull, wr_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fsel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_q <= reg_wdata[2:0];
      if (reg_addr == A_FSEL) fsel_q <= reg_wdata;
    end
  end

  assign buzz_en   = ctrl_q[0];
  assign buzz_shot = ctrl_q[1];
  assign tmr_en    = ctrl_q[2];
  assign fout_en   = (fsel_q != '0);

  altfn_clkout_div u_div (
    .clk(clk), .rst_n(rst_n), .osc_lo(osc_lo), .osc_hi(osc_hi),
    .sel(fsel_q), .clk_out(fout_clk)
  );

  assign alt_en  = {fout_en, tmr_en, buzz_en};
  assign alt_val = {fout_clk, tout_in, buzz_in};

  assign wr_dat  = reg_wr && (reg_addr == A_DATA);
  assign wr_dir  = reg_wr && (reg_addr == A_DIR);
  assign wr_pull = reg_wr && (reg_addr == A_PULL);
  assign wr_lvl  = reg_wr && (reg_addr == A_LVL);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    altfn_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_dat(wr_dat), .wr_dir(wr_dir), .wr_pull(wr_pull), .wr_lvl(wr_lvl),
      .wbit(reg_wdata[i]), .alt_en(alt_en[i]), .alt_val(alt_val[i]),
      .dat_q(dat_v[i]), .dir_q(dir_v[i]), .pull_q(pull_v[i]), .lvl_q(lvl_v[i]),
      .pad_oe(pad_oe[i]), .pad_out(pad_out[i]), .pad_pd(pad_pd[i]), .pad_lvl(pad_lvl[i])
    );
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = {1'b0, dat_v};
      A_DIR:   reg_rdata = {1'b0, dir_v};
      A_PULL:  reg_rdata = {1'b0, pull_v};
      A_LVL:   reg_rdata = {1'b0, lvl_v};
      A_CTRL:  reg_rdata = {1'b0, ctrl_q};
      A_FSEL:  reg_rdata = fsel_q;
      A_PINS:  reg_rdata = {1'b0, pad_in};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/altfn_gpio_port_chk.sv
module altfn_gpio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [3:0] reg_wdata,
  input logic       tout_in,
  input logic [2:0] pad_oe,
  input logic [2:0] pad_out,
  input logic [2:0] pad_pd,
  input logic       tmr_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_pd == 3'b111 && pad_oe == 3'b000));

  // R7
  tout_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en |-> (pad_oe[1] && pad_out[1] == tout_in));

  // R8
  fsel_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5 && reg_wdata != 4'd0) |=> (pad_oe[2] && !pad_pd[2]));

  // R11
  dir_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && reg_wr && reg_addr == 3'd1) |=> pad_oe[1]);

  // R5
  buzz_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) |=> (pad_oe[0] && !pad_pd[0]));
endmodule

bind altfn_gpio_port altfn_gpio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tout_in(tout_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pd(pad_pd), .tmr_en(tmr_en)
);

// File: tb/test_altfn_gpio_port.sv
`timescale 1ns/1ps
module test_altfn_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       buzz_in = 1'b0, tout_in = 1'b0, osc_lo = 1'b0, osc_hi = 1'b0;
  logic       buzz_shot;
  logic [2:0] ext_lvl = 3'b000;
  logic [2:0] pad_in, pad_oe, pad_out, pad_pd, pad_lvl;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;            // 250 MHz
  initial begin #1; forever #20 osc_lo = ~osc_lo; end   // 40 ns period
  initial begin #1; forever #8  osc_hi = ~osc_hi; end   // 16 ns period

  for (genvar i = 0; i < 3; i++) begin : g_pad
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : (pad_pd[i] ? 1'b0 : ext_lvl[i]);
  end

  altfn_gpio_port i_altfn_gpio_port (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [3:0] exp);
    @(negedge clk); reg_addr = a; #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 oe", pad_oe, 3'b000);
    check("R1 pd", pad_pd, 3'b111);
    check("R1 out", pad_out, 3'b000);
    rd_check("R1 data", 3'd0, 4'h0);
    rd_check("R1 dir", 3'd1, 4'h0);
    rd_check("R1 pull", 3'd2, 4'h7);
    rd_check("R1 lvl", 3'd3, 4'h0);
    rd_check("R1 ctrl", 3'd4, 4'h0);
    rd_check("R1 fsel", 3'd5, 4'h0);
  endtask

  task automatic t_gpio;
    wr(3'd0, 4'b0101); wr(3'd1, 4'b0011); wr(3'd2, 4'b0110); wr(3'd3, 4'b0101);
    check("R2 oe", pad_oe, 3'b011);
    check("R2 out", pad_out, 3'b101);
    check("R2 pd", pad_pd, 3'b100);
    check("R2 lvl", pad_lvl, 3'b101);
    rd_check("R3 data", 3'd0, 4'h5);
    rd_check("R3 dir", 3'd1, 4'h3);
    rd_check("R3 pull", 3'd2, 4'h6);
    rd_check("R3 lvl", 3'd3, 4'h5);
    wr(3'd0, 4'hF);
    rd_check("R3 mask", 3'd0, 4'h7);
    wr(3'd5, 4'hB); rd_check("R3 fsel", 3'd5, 4'hB); wr(3'd5, 4'h0);
    // pin0 drives 1, pin1 drives 1, pin2 input pull-down off, ext 1
    wr(3'd2, 4'b0000); ext_lvl = 3'b100;
    rd_check("R4 pins", 3'd6, 4'b0111);
    wr(3'd2, 4'b0100);
    rd_check("R4 pins pd", 3'd6, 4'b0011);
    wr(3'd6, 4'hF);
    rd_check("R4 no write", 3'd0, 4'h7);
    wr(3'd0, 4'h0); wr(3'd1, 4'h0); wr(3'd2, 4'h7); wr(3'd3, 4'h0); ext_lvl = 3'b000;
  endtask

  task automatic t_buzzer;
    wr(3'd4, 4'b0001);
    buzz_in = 1'b1; @(negedge clk);
    check("R5 oe", pad_oe[0], 1'b1);
    check("R5 out", pad_out[0], 1'b1);
    check("R5 pd", pad_pd[0], 1'b0);
    buzz_in = 1'b0; @(negedge clk);
    check("R5 out low", pad_out[0], 1'b0);
    wr(3'd4, 4'b0010);
    check("R6 shot", buzz_shot, 1'b1);
    check("R6 pads oe", pad_oe, 3'b000);
    check("R6 pads pd", pad_pd, 3'b111);
    wr(3'd4, 4'b0000);
    check("R6 shot off", buzz_shot, 1'b0);
  endtask

  task automatic t_timer;
    wr(3'd4, 4'b0100);
    check("R7 oe", pad_oe[1], 1'b1);
    @(posedge clk); #1 tout_in = 1'b1; #0.2;
    check("R7 same cycle high", pad_out[1], 1'b1);
    #1 tout_in = 1'b0; #0.2;
    check("R7 same cycle low", pad_out[1], 1'b0);
    // R11: registers ignored while override active
    wr(3'd1, 4'b0000); wr(3'd0, 4'b0010); wr(3'd2, 4'b0010); wr(3'd3, 4'b0010);
    check("R11 oe kept", pad_oe[1], 1'b1);
    check("R11 out", pad_out[1], 1'b0);
    check("R11 pd", pad_pd[1], 1'b0);
    check("R11 lvl", pad_lvl[1], 1'b0);
    rd_check("R11 readback", 3'd0, 4'h2);
    wr(3'd4, 4'b0000);
    check("R11 restore oe", pad_oe[1], 1'b0);
    check("R11 restore pd", pad_pd[1], 1'b1);
    check("R11 restore lvl", pad_lvl[1], 1'b1);
    wr(3'd0, 4'h0); wr(3'd3, 4'h0); wr(3'd2, 4'h7);
  endtask

  task automatic t_fout;
    check("R8 gpio", pad_oe[2], 1'b0);
    for (int c = 1; c < 16; c++) begin
      realtime t0, t1, exp;
      wr(3'd5, 4'(c));
      check("R8 output", {pad_oe[2], pad_pd[2]}, 2'b10);
      @(posedge pad_out[2]); @(posedge pad_out[2]); t0 = $realtime;
      @(posedge pad_out[2]); t1 = $realtime;
      if (c < 8) begin
        exp = 40.0 * (1 << (c - 1));
        check($sformatf("R9 code %0d", c), int'(t1 - t0), int'(exp));
      end else begin
        exp = 16.0 * (1 << (c - 8));
        check($sformatf("R10 code %0d", c), int'(t1 - t0), int'(exp));
      end
    end
    wr(3'd5, 4'h0);
    check("R8 back to gpio", {pad_oe[2], pad_pd[2]}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gpio();
    t_buzzer();
    t_timer();
    t_fout();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule